// File: doc/BRIEF.md
# Framed Serial-to-Vector Deserializer

This block gathers a fast stream of scalar samples into a wide vector that changes at a slower rate. The slow rate has no clock of its own: a free-running slot counter splits time into output periods of `RATIO + IDLE_CYCLES` input cycles. The first `RATIO` slots of each period are data slots and the remaining ones are idle slots. At every period boundary the block raises a one-cycle output strobe. It presents the most recently completed vector on that strobe, with a valid flag.

In framed mode a vector is built only between framing events. A start strobe that coincides with a valid sample opens a new vector. Later valid samples fill it lane by lane. A start that arrives too early throws away the partial vector and begins again. In free-running mode the framing inputs are ignored, and every data slot is taken. If no vector completed during a period, the output keeps its previous contents and the valid flag stays low. Until the first vector completes, the output shows a parameterised initial value.

Top module: `framed_deser`

## Requirements
- R1: A vector holds `RATIO` accepted samples in arrival order. The first accepted sample goes to lane 0, which is bits `[DATA_W-1:0]` of `vec_out`, and lane i is bits `[i*DATA_W +: DATA_W]`.
- R2: `slow_stb` is high for exactly one cycle every `RATIO + IDLE_CYCLES` cycles. The first pulse follows the edge that completes slot `RATIO + IDLE_CYCLES - 1` after reset.
- R3: A completed vector appears on `vec_out` at the first `slow_stb` after its last sample. `vec_valid` is high only in a `slow_stb` cycle, and only once per completed vector.
- R4: In framed mode (`FRAMED=1`), collection opens only when `din_start` and `din_valid` are both high in a data slot. A sample with `din_valid` low is dropped, and a start with `din_valid` low does not restart collection. A valid sample is also dropped when no collection is open and `din_start` is low.
- R5: In framed mode, a start accompanied by valid that arrives before `RATIO` samples are held discards the partial samples. Collection restarts, with that sample placed in lane 0. A collection may span period boundaries.
- R6: If no vector completed during a period, `vec_out` keeps its previous value at the next `slow_stb`, and `vec_valid` is low. `vec_out` changes only in a `slow_stb` cycle.
- R7: Idle slots, which are slots `RATIO` to `RATIO + IDLE_CYCLES - 1` of each period, never supply samples, even when `din_valid` is high.
- R8: In free-running mode (`FRAMED=0`), `din_valid` and `din_start` are ignored. Data slot i of each period fills lane i, and every `slow_stb` carries a new vector with `vec_valid` high.
- R9: A synchronous active-high `rst` clears the collection state, loads `INIT_VALUE` into `vec_out`, and drives `vec_valid` and `slow_stb` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Scalar input sample |
| din_valid | input | 1 | Qualifies `din` (framed mode only) |
| din_start | input | 1 | Opens a new vector (framed mode only) |
| vec_out | output | RATIO*DATA_W | Assembled vector, lane 0 in the low bits |
| vec_valid | output | 1 | New vector presented in this strobe cycle |
| slow_stb | output | 1 | One-cycle pulse marking each output period |

## Verification
A fill counter that skips a lane or counts an idle slot would show up as a wrong vector, or as a missing `vec_valid`, at the very next strobe. So a single period of directed data pins down most faults. A restart that fails to clear the partial vector would complete it one period too early, using stale lanes. Lost pending state would show up as a held vector where a valid one was expected, one strobe after completion. The slot timer is visible directly through the strobe spacing from the first period onward.

// File: rtl/deser_pkg.sv
package deser_pkg;
   // Width of a counter that must hold values 0..max_val, never below 1.
   function automatic int unsigned cnt_width(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction
endpackage

// File: rtl/deser_slot_timer.sv
module deser_slot_timer #(
   parameter int unsigned RATIO       = 4,
   parameter int unsigned IDLE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst,
   output logic data_slot,
   output logic boundary
);
   localparam int unsigned PERIOD = RATIO + IDLE_CYCLES;
   localparam int unsigned PH_W   = deser_pkg::cnt_width(PERIOD);

   logic [PH_W-1:0] phase_q;
   logic            last_slot;

   assign last_slot = (phase_q == PH_W'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (rst)            phase_q <= '0;
      else if (last_slot) phase_q <= '0;
      else                phase_q <= phase_q + 1'b1;
   end

   generate
      if (IDLE_CYCLES == 0) begin : g_no_idle
         assign data_slot = 1'b1;
      end else begin : g_idle
         assign data_slot = (phase_q < PH_W'(RATIO));
      end
   endgenerate

   assign boundary = last_slot;
endmodule

// File: rtl/deser_collect.sv
module deser_collect #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned RATIO  = 4,
   parameter bit          FRAMED = 1'b1,
   parameter int unsigned CNT_W  = 3,
   localparam int unsigned VEC_W = RATIO * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   input  logic              din_valid,
   input  logic              din_start,
   input  logic              data_slot,
   output logic              accept,
   output logic              done,
   output logic [VEC_W-1:0]  done_vec,
   output logic [CNT_W-1:0]  fill
);
   logic [DATA_W-1:0] lane_q [RATIO];
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  wr_idx;
   logic [CNT_W-1:0]  next_cnt;
   logic              active_q;
   logic              take_start;
   logic              take_cont;

   // Acceptance variant chosen by the framing option.
   generate
      if (FRAMED) begin : g_framed
         assign take_start = data_slot & din_valid & din_start;
         assign take_cont  = data_slot & din_valid & ~din_start & active_q;
      end else begin : g_free
         logic unused_framing;
         assign unused_framing = din_valid ^ din_start ^ active_q;
         assign take_start = data_slot & (cnt_q == '0);
         assign take_cont  = data_slot & (cnt_q != '0);
      end
   endgenerate

   assign accept   = take_start | take_cont;
   assign wr_idx   = take_start ? '0 : cnt_q;
   assign next_cnt = wr_idx + 1'b1;
   assign done     = accept && (next_cnt == CNT_W'(RATIO));
   assign fill     = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (done) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (accept) begin
         cnt_q    <= next_cnt;
         active_q <= 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < RATIO; i++) begin : g_lane
         logic hit;
         assign hit = accept && (wr_idx == CNT_W'(i));
         always_ff @(posedge clk) begin
            if (rst)      lane_q[i] <= '0;
            else if (hit) lane_q[i] <= din;
         end
         assign done_vec[i*DATA_W +: DATA_W] = hit ? din : lane_q[i];
      end
   endgenerate
endmodule

// File: rtl/deser_emit.sv
module deser_emit #(
   parameter int unsigned            VEC_W      = 32,
   parameter logic [VEC_W-1:0]       INIT_VALUE = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             boundary,
   input  logic             done,
   input  logic [VEC_W-1:0] done_vec,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_valid,
   output logic             slow_stb
);
   logic [VEC_W-1:0] pend_q;
   logic             pend_vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q     <= '0;
         pend_vld_q <= 1'b0;
         vec_out    <= INIT_VALUE;
         vec_valid  <= 1'b0;
         slow_stb   <= 1'b0;
      end else begin
         slow_stb <= boundary;
         if (boundary) begin
            pend_vld_q <= 1'b0;
            if (done) begin
               vec_out   <= done_vec;
               vec_valid <= 1'b1;
            end else if (pend_vld_q) begin
               vec_out   <= pend_q;
               vec_valid <= 1'b1;
            end else begin
               vec_valid <= 1'b0;
            end
         end else begin
            vec_valid <= 1'b0;
            if (done) begin
               pend_q     <= done_vec;
               pend_vld_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/framed_deser.sv
module framed_deser #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned RATIO       = 4,
   parameter int unsigned IDLE_CYCLES = 2,
   parameter bit          FRAMED      = 1'b1,
   parameter logic [RATIO*DATA_W-1:0] INIT_VALUE = '0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [DATA_W-1:0]       din,
   input  logic                    din_valid,
   input  logic                    din_start,
   output logic [RATIO*DATA_W-1:0] vec_out,
   output logic                    vec_valid,
   output logic                    slow_stb
);
   localparam int unsigned VEC_W = RATIO * DATA_W;
   localparam int unsigned CNT_W = deser_pkg::cnt_width(RATIO);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("framed_deser: DATA_W must be at least 1");
      end
      if (RATIO < 1) begin : g_bad_ratio
         $error("framed_deser: RATIO must be at least 1");
      end
   endgenerate

   logic             data_slot;
   logic             boundary;
   logic             accept;
   logic             done;
   logic [VEC_W-1:0] done_vec;
   logic [CNT_W-1:0] fill;

   deser_slot_timer #(
      .RATIO       (RATIO),
      .IDLE_CYCLES (IDLE_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst       (rst),
      .data_slot (data_slot),
      .boundary  (boundary)
   );

   deser_collect #(
      .DATA_W (DATA_W),
      .RATIO  (RATIO),
      .FRAMED (FRAMED),
      .CNT_W  (CNT_W)
   ) u_collect (
      .clk       (clk),
      .rst       (rst),
      .din       (din),
      .din_valid (din_valid),
      .din_start (din_start),
      .data_slot (data_slot),
      .accept    (accept),
      .done      (done),
      .done_vec  (done_vec),
      .fill      (fill)
   );

   deser_emit #(
      .VEC_W      (VEC_W),
      .INIT_VALUE (INIT_VALUE)
   ) u_emit (
      .clk       (clk),
      .rst       (rst),
      .boundary  (boundary),
      .done      (done),
      .done_vec  (done_vec),
      .vec_out   (vec_out),
      .vec_valid (vec_valid),
      .slow_stb  (slow_stb)
   );
endmodule

// File: rtl/framed_deser_chk.sv
module framed_deser_chk #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned RATIO       = 4,
   parameter int unsigned IDLE_CYCLES = 2,
   parameter logic [RATIO*DATA_W-1:0] INIT_VALUE = '0,
   parameter int unsigned CNT_W = 3
) (
   input logic                    clk,
   input logic                    rst,
   input logic [RATIO*DATA_W-1:0] vec_out,
   input logic                    vec_valid,
   input logic                    slow_stb,
   input logic                    data_slot,
   input logic                    accept,
   input logic [CNT_W-1:0]        fill
);
   localparam int unsigned PERIOD = RATIO + IDLE_CYCLES;
   localparam int unsigned GAP_W  = deser_pkg::cnt_width(PERIOD);

   logic [GAP_W-1:0] gap_q;
   logic             rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)                             gap_q <= '0;
      else if (gap_q == GAP_W'(PERIOD-1))  gap_q <= '0;
      else                                 gap_q <= gap_q + 1'b1;
   end

   // R2: strobe spacing equals the output period
   a_r2_stb_spacing: assert property (@(posedge clk) disable iff (rst)
      slow_stb |-> (gap_q == '0));

   // R3: valid flag only accompanies a strobe
   a_r3_valid_on_stb: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> slow_stb);

   // R6: output vector changes only in a strobe cycle
   a_r6_change_on_stb: assert property (@(posedge clk) disable iff (rst)
      !$stable(vec_out) |-> slow_stb);

   // R6: a strobe without a new vector keeps the old one
   a_r6_hold_no_valid: assert property (@(posedge clk) disable iff (rst)
      (slow_stb && !vec_valid) |-> $stable(vec_out));

   // R7: idle slots never supply a sample
   a_r7_idle_ignored: assert property (@(posedge clk) disable iff (rst)
      !data_slot |-> !accept);

   // R1: held sample count stays below a full vector
   a_r1_fill_bound: assert property (@(posedge clk) disable iff (rst)
      fill < CNT_W'(RATIO));

   // R9: state right after reset
   a_r9_reset_state: assert property (@(posedge clk)
      (rst_q === 1'b1) |-> (vec_out == INIT_VALUE && !vec_valid && !slow_stb));
endmodule

bind framed_deser framed_deser_chk #(
   .DATA_W      (DATA_W),
   .RATIO       (RATIO),
   .IDLE_CYCLES (IDLE_CYCLES),
   .INIT_VALUE  (INIT_VALUE),
   .CNT_W       (CNT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .vec_out   (vec_out),
   .vec_valid (vec_valid),
   .slow_stb  (slow_stb),
   .data_slot (data_slot),
   .accept    (accept),
   .fill      (fill)
);

// File: tb/framed_deser_tb.sv
`timescale 1ns/1ps
module framed_deser_tb;
   localparam int unsigned W   = 8;
   localparam int unsigned R   = 4;
   localparam int unsigned IDL = 2;
   localparam logic [R*W-1:0] INIT = 32'hDEAD_BEEF;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] din = '0;
   logic         dv  = 1'b0;
   logic         ds  = 1'b0;
   logic [R*W-1:0] f_vec, r_vec;
   logic           f_vld, r_vld, f_stb, r_stb;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   framed_deser #(.DATA_W(W), .RATIO(R), .IDLE_CYCLES(IDL), .FRAMED(1'b1),
                  .INIT_VALUE(INIT)) u_dut (
      .clk(clk), .rst(rst), .din(din), .din_valid(dv), .din_start(ds),
      .vec_out(f_vec), .vec_valid(f_vld), .slow_stb(f_stb));

   framed_deser #(.DATA_W(W), .RATIO(R), .IDLE_CYCLES(IDL), .FRAMED(1'b0),
                  .INIT_VALUE(INIT)) u_free (
      .clk(clk), .rst(rst), .din(din), .din_valid(dv), .din_start(ds),
      .vec_out(r_vec), .vec_valid(r_vld), .slow_stb(r_stb));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; dv = 1'b0; ds = 1'b0; din = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   // One input slot: drive at falling edge, return just after the rising edge.
   task automatic slot(input logic [W-1:0] d, input logic v, input logic s);
      @(negedge clk);
      din = d; dv = v; ds = s;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      do_reset();
      check("R9 framed vec_out init", f_vec, INIT);
      check("R9 framed vec_valid low", f_vld, 0);
      check("R9 framed slow_stb low", f_stb, 0);
      check("R9 free vec_out init", r_vec, INIT);
      check("R9 free vec_valid low", r_vld, 0);
   endtask

   task automatic t_basic();
      do_reset();
      slot(8'h11, 1, 1); slot(8'h22, 1, 0); slot(8'h33, 1, 0); slot(8'h44, 1, 0);
      check("R2 no strobe mid period", f_stb, 0);
      check("R3 vector not early", f_vec, INIT);
      slot(8'hEE, 1, 0); slot(8'hEF, 1, 0);
      check("R2 strobe at period end", f_stb, 1);
      check("R1 lane order framed", f_vec, 32'h44332211);
      check("R3 valid with strobe", f_vld, 1);
      check("R8 free vector", r_vec, 32'h44332211);
      check("R8 free valid", r_vld, 1);
      slot(8'h50, 0, 0);
      check("R3 valid one cycle", f_vld, 0);
      check("R2 strobe one cycle", f_stb, 0);
      slot(8'h51, 0, 0); slot(8'h52, 0, 0); slot(8'h53, 0, 0);
      slot(8'h54, 0, 0); slot(8'h55, 0, 0);
      check("R6 hold previous vector", f_vec, 32'h44332211);
      check("R6 valid low on empty period", f_vld, 0);
      check("R2 second strobe", f_stb, 1);
      check("R8 free ignores valid", r_vec, 32'h53525150);
      check("R8 free valid every period", r_vld, 1);
   endtask

   task automatic t_drop();
      do_reset();
      slot(8'hAA, 0, 1); slot(8'hBB, 1, 0); slot(8'hCC, 0, 0); slot(8'hDD, 0, 1);
      slot(8'h00, 0, 0); slot(8'h00, 0, 0);
      check("R4 dropped samples keep init", f_vec, INIT);
      check("R4 no valid after drops", f_vld, 0);
      slot(8'h01, 1, 1); slot(8'h02, 1, 0); slot(8'h03, 1, 0); slot(8'h04, 1, 0);
      slot(8'h00, 0, 0); slot(8'h00, 0, 0);
      check("R4 framed collection after drops", f_vec, 32'h04030201);
      check("R4 valid after framed vector", f_vld, 1);
   endtask

   task automatic t_restart();
      do_reset();
      slot(8'hA1, 1, 1); slot(8'hA2, 1, 0); slot(8'hC1, 1, 1); slot(8'hC2, 1, 0);
      slot(8'hFF, 1, 0); slot(8'hFE, 1, 0);
      check("R5 R7 no completion in first period", f_vec, INIT);
      check("R5 valid low first period", f_vld, 0);
      slot(8'hC3, 1, 0); slot(8'hC4, 1, 0);
      slot(8'h00, 0, 0); slot(8'h00, 0, 0); slot(8'h00, 0, 0); slot(8'h00, 0, 0);
      check("R5 restarted vector", f_vec, 32'hC4C3C2C1);
      check("R5 restarted valid", f_vld, 1);
   endtask

   task automatic t_gap();
      do_reset();
      slot(8'h01, 1, 1); slot(8'h99, 0, 1); slot(8'h02, 1, 0); slot(8'h03, 1, 0);
      slot(8'h00, 0, 0); slot(8'h00, 0, 0);
      check("R4 partial not emitted", f_vld, 0);
      slot(8'h77, 0, 0); slot(8'h04, 1, 0);
      slot(8'h00, 0, 0); slot(8'h00, 0, 0); slot(8'h00, 0, 0); slot(8'h00, 0, 0);
      check("R4 start without valid ignored", f_vec, 32'h04030201);
      check("R3 valid after spanning vector", f_vld, 1);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_drop();
      t_restart();
      t_gap();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule